// File: doc/BRIEF.md
# UART Register Front-End on APB

This block sits between an APB bus and a byte-level UART core. It has no serial timing and no baud logic. It presents five word registers: a data port, a read-only status word, a control word, and two reserved words (a scaler and a FIFO-debug slot) that read as zero. Received bytes arrive on a valid/ready stream and wait in a 16-entry FIFO until the CPU reads the data port. Bytes the CPU writes to the data port leave on a second valid/ready stream through a one-byte holding stage.

The control word gates both directions and picks which events raise the single interrupt line. Parity, flow control, loopback, external clock, FIFO-interrupt, debug and output-enable bits are stored and read back, but nothing acts on them. The data port also answers at byte offset 3, so byte-wide CPU accesses work.

The transmit side is a two-state machine:
- `HOLD_IDLE`: nothing is pending.
- `HOLD_BUSY`: a byte is offered on the outgoing stream.

Its transitions are:
- `load` (`HOLD_IDLE` to `HOLD_BUSY`).
- `drain` (`HOLD_BUSY` to `HOLD_IDLE`, when the sink is ready and no new byte arrives).
- `reload` (`HOLD_BUSY` to `HOLD_BUSY`, when the sink takes the byte in the same cycle that a new one is written).

Top module: `uart_apb_regs`

## Requirements
- R1: After reset, control reads 0x8000_0000, the receive FIFO is empty, status reads 0x0000_0006, and `irq`, `rx_ready` and `tx_valid` are low.
- R2: `rx_ready` is high only while control bit 0 (receive enable) is set. With that bit clear, no byte enters the FIFO.
- R3: The FIFO keeps up to 16 bytes in arrival order. `rx_ready` is low while it holds 16. Status bit 10 is set at 16 entries and status bit 8 at 8 or more entries.
- R4: A read at offset 0x00 or 0x03 returns the oldest stored byte in bits 7:0 and removes it. A read with the FIFO empty returns 0 and changes nothing.
- R5: Status bit 0 is set exactly while at least one unread byte is stored. Bits 3..7 always read 0.
- R6: A write at offset 0x00 or 0x03 while control bit 1 (transmit enable) is set loads `pwdata[7:0]` for sending. With bit 1 clear, the write has no effect.
- R7: While a byte is pending, `tx_valid` is high, `tx_data` is steady, status bits 1 and 2 read 0 and status bit 9 reads 1. A data write while the byte is pending and `tx_ready` is low is dropped.
- R8: `irq` is high for the cycle after a cycle in which a byte was accepted with control bit 2 set, or a transmit byte was loaded with control bit 3 set. Both events in one cycle give a single pulse.
- R9: A write at offset 0x08 stores `pwdata[12:0]`. A control read returns those bits, with bit 31 set and all other bits 0.
- R10: Offsets 0x0C, 0x10 and every unmapped offset read 0. Writes to them, and to status at 0x04, change no register.
- R11: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Incoming byte accepted |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Sink accepts outgoing byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench fills the FIFO past 16 entries with a stream that never drops valid. A design that leaves `rx_ready` high at full would overwrite the oldest byte and return the wrong sequence on later reads.

It reads the data port once the FIFO is empty, at both offset 0 and offset 3. An underflowing pointer would return stale data and raise the half or full flags. It writes a second byte while the first is stalled; a design that overwrote the hold register would emit the wrong byte.

It also lines up a receive accept and a transmit load in the same cycle, where a split interrupt would show a second pulse. Finally, it writes the status and reserved offsets, which a loose address decode would turn into control or transmit updates.

// File: rtl/uart_apb_pkg.sv
package uart_apb_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 32;

    localparam int OFS_DATA   = 0;
    localparam int OFS_DATA_B = 3;
    localparam int OFS_STAT   = 4;
    localparam int OFS_CTRL   = 8;

    localparam int CTRL_W        = 13;
    localparam int CB_RX_EN      = 0;
    localparam int CB_TX_EN      = 1;
    localparam int CB_RX_IE      = 2;
    localparam int CB_TX_IE      = 3;
    localparam int CB_FIFO_AVAIL = 31;

    localparam int SB_RX_AVAIL = 0;
    localparam int SB_SHIFT_MT = 1;
    localparam int SB_TXQ_MT   = 2;
    localparam int SB_RXQ_HALF = 8;
    localparam int SB_TXQ_FULL = 9;
    localparam int SB_RXQ_FULL = 10;

    typedef enum logic {HOLD_IDLE, HOLD_BUSY} hold_state_e;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [uart_apb_pkg::BYTE_W-1:0] push_data,
    input  logic                          pop,
    output logic [uart_apb_pkg::BYTE_W-1:0] head,
    output logic                          empty,
    output logic                          half,
    output logic                          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);

    logic [uart_apb_pkg::BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_FULL);
    assign half  = (count >= CNT_HALF);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [uart_apb_pkg::BYTE_W-1:0] load_data,
    input  logic                            tx_ready,
    output logic                            tx_valid,
    output logic [uart_apb_pkg::BYTE_W-1:0] tx_data,
    output logic                            busy,
    output logic                            can_load
);
    import uart_apb_pkg::*;

    hold_state_e state, state_nx;
    logic [BYTE_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HOLD_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= load_data;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            HOLD_IDLE: if (load) state_nx = HOLD_BUSY;
            HOLD_BUSY: if (tx_ready) state_nx = load ? HOLD_BUSY : HOLD_IDLE;
            default:   state_nx = HOLD_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = 1'b0;
        busy     = 1'b0;
        can_load = 1'b1;
        unique case (state)
            HOLD_IDLE: begin
                tx_valid = 1'b0;
                busy     = 1'b0;
                can_load = 1'b1;
            end
            HOLD_BUSY: begin
                tx_valid = 1'b1;
                busy     = 1'b1;
                can_load = tx_ready;
            end
            default: ;
        endcase
    end

    assign tx_data = hold_q;

    assert_tx_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/uart_irq_pulse.sv
module uart_irq_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_evt,
    input  logic tx_evt,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= rx_evt | tx_evt;
    end
endmodule

// File: rtl/uart_apb_regs.sv
module uart_apb_regs #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              irq
);
    import uart_apb_pkg::*;

    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DATA_B = ADDR_W'(OFS_DATA_B);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

    logic [CTRL_W-1:0] ctrl_q;
    logic access, hit_data, hit_ctrl, data_rd, data_wr;
    logic rx_push, rx_pop, tx_load;
    logic fifo_empty, fifo_half, fifo_full;
    logic [BYTE_W-1:0] fifo_head;
    logic hold_busy, hold_can_load;
    logic [REG_W-1:0] status_w, ctrl_w;
    logic unused_bits;

    assign access   = psel & penable;
    assign hit_data = (paddr == A_DATA) || (paddr == A_DATA_B);
    assign hit_ctrl = (paddr == A_CTRL);
    assign data_rd  = access & ~pwrite & hit_data;
    assign data_wr  = access &  pwrite & hit_data;

    assign rx_ready = ctrl_q[CB_RX_EN] & ~fifo_full;
    assign rx_push  = rx_valid & rx_ready;
    assign rx_pop   = data_rd & ~fifo_empty;
    assign tx_load  = data_wr & ctrl_q[CB_TX_EN] & hold_can_load;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)                        ctrl_q <= '0;
        else if (access && pwrite && hit_ctrl) ctrl_q <= pwdata[CTRL_W-1:0];
    end

    uart_rx_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk(pclk), .rst_n(presetn),
        .push(rx_push), .push_data(rx_data), .pop(rx_pop),
        .head(fifo_head), .empty(fifo_empty), .half(fifo_half), .full(fifo_full)
    );

    uart_tx_hold u_tx_hold (
        .clk(pclk), .rst_n(presetn),
        .load(tx_load), .load_data(pwdata[BYTE_W-1:0]), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .busy(hold_busy), .can_load(hold_can_load)
    );

    uart_irq_pulse u_irq (
        .clk(pclk), .rst_n(presetn),
        .rx_evt(rx_push & ctrl_q[CB_RX_IE]),
        .tx_evt(tx_load & ctrl_q[CB_TX_IE]),
        .irq(irq)
    );

    always_comb begin
        status_w              = '0;
        status_w[SB_RX_AVAIL] = ~fifo_empty;
        status_w[SB_SHIFT_MT] = ~hold_busy;
        status_w[SB_TXQ_MT]   = ~hold_busy;
        status_w[SB_RXQ_HALF] = fifo_half;
        status_w[SB_TXQ_FULL] = hold_busy;
        status_w[SB_RXQ_FULL] = fifo_full;
        ctrl_w                = '0;
        ctrl_w[CTRL_W-1:0]    = ctrl_q;
        ctrl_w[CB_FIFO_AVAIL] = 1'b1;
    end

    always_comb begin
        prdata = '0;
        if (access && !pwrite) begin
            if (hit_data)              prdata = fifo_empty ? '0 : REG_W'(fifo_head);
            else if (paddr == A_STAT)  prdata = status_w;
            else if (hit_ctrl)         prdata = ctrl_w;
            else                       prdata = '0;
        end
    end

    assign pready      = 1'b1;
    assign pslverr     = 1'b0;
    assign unused_bits = ^pwdata[31:CTRL_W];

    assert_rx_gate_R2: assert property (@(posedge pclk) disable iff (!presetn)
        rx_ready |-> ctrl_q[CB_RX_EN]);
    assert_irq_source_R8: assert property (@(posedge pclk) disable iff (!presetn)
        irq |-> ($past(ctrl_q[CB_RX_IE]) || $past(ctrl_q[CB_TX_IE])));
    assert_tx_needs_enable_R6: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(tx_valid) |-> $past(ctrl_q[CB_TX_EN]));
endmodule

// File: tb/uart_apb_regs_bench.sv
`timescale 1ns/1ps
module uart_apb_regs_bench;
    logic clk = 0, presetn = 0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [7:0] paddr = 0;
    logic [31:0] pwdata = 0, prdata;
    logic pready, pslverr;
    logic rx_valid = 0, rx_ready, tx_valid, tx_ready = 0, irq;
    logic [7:0] rx_data = 0, tx_data;

    int checks = 0, errors = 0;
    int mq[$];
    logic [12:0] mctrl = 0;
    bit mhold_full = 0, mirq = 0;
    logic [7:0] mhold = 0;
    logic [31:0] last_rd = 0;

    always #2.5 clk = ~clk;

    uart_apb_regs u_uart_apb_regs (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] off);
        logic [31:0] s = 0;
        case (off)
            8'd0, 8'd3: return (mq.size() > 0) ? 32'(mq[0]) : 32'd0;
            8'd4: begin
                s[0] = mq.size() > 0;
                s[1] = !mhold_full;
                s[2] = !mhold_full;
                s[8] = mq.size() >= 8;
                s[9] = mhold_full;
                s[10] = mq.size() == 16;
                return s;
            end
            8'd8: return {1'b1, 18'd0, mctrl};
            default: return 32'd0;
        endcase
    endfunction

    task automatic tick();
        bit exp_rdy, acc, push, pop, drain, load, isdata;
        logic [31:0] e;
        string tag;
        #1;
        exp_rdy = mctrl[0] && mq.size() < 16;
        chk(rx_ready === exp_rdy, mctrl[0] ? "R3" : "R2", 32'(rx_ready), 32'(exp_rdy));
        chk(tx_valid === mhold_full, "R7", 32'(tx_valid), 32'(mhold_full));
        if (mhold_full) chk(tx_data === mhold, "R6", 32'(tx_data), 32'(mhold));
        chk(irq === mirq, "R8", 32'(irq), 32'(mirq));
        chk(pready === 1'b1 && pslverr === 1'b0, "R11", {pready, pslverr}, 32'd2);
        acc = psel && penable;
        isdata = (paddr == 8'd0) || (paddr == 8'd3);
        if (acc && !pwrite) begin
            e = exp_read(paddr);
            tag = isdata ? "R4" : (paddr == 8'd4) ? "R5" : (paddr == 8'd8) ? "R9" : "R10";
            chk(prdata === e, tag, prdata, e);
            last_rd = prdata;
        end
        push  = rx_valid && exp_rdy;
        pop   = acc && !pwrite && isdata && mq.size() > 0;
        drain = mhold_full && tx_ready;
        load  = acc && pwrite && isdata && mctrl[1] && (!mhold_full || drain);
        @(posedge clk);
        mirq = (push && mctrl[2]) || (load && mctrl[3]);
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(int'(rx_data));
        if (drain) mhold_full = 0;
        if (load) begin mhold_full = 1; mhold = pwdata[7:0]; end
        if (acc && pwrite && paddr == 8'd8) mctrl = pwdata[12:0];
        @(negedge clk);
    endtask

    task automatic apb(bit wr, logic [7:0] a, logic [31:0] d);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        tick();
        penable = 1;
        tick();
        psel = 0; penable = 0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] addrs [7] = '{8'd0, 8'd3, 8'd4, 8'd8, 8'd12, 8'd16, 8'd20};
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        presetn = 1;
        // R1 reset state
        #1;
        chk(rx_ready === 0 && tx_valid === 0 && irq === 0, "R1",
            {rx_ready, tx_valid, irq}, 32'd0);
        @(negedge clk);
        apb(0, 8'd4, 0); chk(last_rd === 32'h6, "R1", last_rd, 32'h6);
        apb(0, 8'd8, 0); chk(last_rd === 32'h8000_0000, "R1", last_rd, 32'h8000_0000);
        // R2 receive disabled: byte offered but not taken
        rx_valid = 1; rx_data = 8'h5A;
        repeat (3) tick();
        rx_valid = 0;
        apb(0, 8'd4, 0); chk(last_rd[0] === 1'b0, "R2", last_rd, 32'h6);
        // R3 fill past depth
        apb(1, 8'd8, 32'h0000_000F);
        rx_valid = 1;
        for (int i = 0; i < 20; i++) begin rx_data = 8'h40 + 8'(i); tick(); end
        rx_valid = 0;
        apb(0, 8'd4, 0); chk(last_rd[10] === 1'b1, "R3", last_rd, 32'h507);
        // R4 drain through both offsets, then empty read
        for (int i = 0; i < 16; i++) apb(0, (i % 2) ? 8'd3 : 8'd0, 0);
        apb(0, 8'd3, 0); chk(last_rd === 0, "R4", last_rd, 0);
        apb(0, 8'd4, 0); chk(last_rd[0] === 1'b0, "R5", last_rd, 32'h6);
        // R7 stalled hold, second write dropped
        tx_ready = 0;
        apb(1, 8'd3, 32'h0000_00A5);
        apb(1, 8'd0, 32'h0000_0011);
        apb(0, 8'd4, 0); chk(last_rd[2:1] === 2'b00 && last_rd[9], "R7", last_rd, 32'h200);
        tx_ready = 1; tick(); tick();
        // R8 simultaneous receive accept and transmit load
        rx_valid = 1; rx_data = 8'h77;
        apb(1, 8'd0, 32'h0000_0033);
        rx_valid = 0; tick(); tick();
        // R6 transmit disabled write ignored
        apb(1, 8'd8, 32'h0000_1FF1);
        apb(1, 8'd0, 32'h0000_0099);
        tick();
        // R10 writes to status and reserved offsets
        apb(1, 8'd4, 32'hFFFF_FFFF);
        apb(1, 8'd12, 32'hFFFF_FFFF);
        apb(1, 8'd16, 32'hFFFF_FFFF);
        apb(1, 8'd20, 32'hFFFF_FFFF);
        apb(0, 8'd8, 0); chk(last_rd === 32'h8000_1FF1, "R9", last_rd, 32'h8000_1FF1);
        apb(0, 8'd12, 0); apb(0, 8'd16, 0); apb(0, 8'd20, 0);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            rx_valid = ($urandom % 2) == 0;
            rx_data  = 8'($urandom);
            tx_ready = ($urandom % 3) != 0;
            if ($urandom % 4 == 0) begin
                logic [7:0] a = addrs[$urandom % 7];
                bit wr = ($urandom % 2) == 0;
                logic [31:0] d = $urandom;
                if (a == 8'd8) d[0] = ($urandom % 4) != 0;
                apb(wr, a, d);
            end else begin
                tick();
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule